// File: doc/BRIEF.md
# Multi-mode double-precision min/max unit

This unit picks the minimum or the maximum of two 64-bit IEEE 754 double-precision operands. A 4-bit mode code selects the variant. The mode chooses min or max, and it chooses plain ordering or a magnitude-first ordering. It also chooses one of four conventions for NaN inputs and signed zeros: the 2008 "number" rules, the 2019 minimum/maximum rules, the 2019 minimumNumber/maximumNumber rules, or a plain compare-and-select. The compare-and-select convention returns the second operand whenever the comparison does not hold. All sixteen variants share one classification stage, one sign-magnitude comparator and one NaN-propagation selector.

The datapath is combinational, and a single output register stage follows it. An operation presented with `in_valid` high appears at the outputs on the next clock edge. The outputs are the selected value and a destination write enable. A sticky flag records every signaling NaN seen since reset. When the invalid-operation exception is enabled and a signaling NaN is present, the write enable is withheld, so the destination keeps its old value.

Top module: `fmm_unit`

## Requirements
- R1: The mode is decoded as follows. `mode[3]` set selects max and clear selects min. `mode[2]` set selects the magnitude-first variant. `mode[1:0]` selects the NaN convention: 00 is the 2008 number rules, 01 is the 2019 minimum/maximum rules, 10 is the 2019 number rules, and 11 is compare-select.
- R2: An operand is a NaN when its bits with bit 63 cleared are unsigned-greater than 0x7FF0000000000000. A NaN is signaling when bit 51 is 0. Quieting a NaN sets bit 51 and leaves every other bit unchanged.
- R3: Convention 00 with a NaN input applies the first matching rule in this order: a signaling A gives A quieted; a signaling B gives B quieted; two NaNs give A quieted; one NaN gives the other operand unchanged.
- R4: Convention 01 with any NaN input returns A quieted if A is a NaN, and B quieted otherwise.
- R5: Convention 10 with two NaNs returns A quieted. With exactly one NaN it returns the other operand unchanged.
- R6: Convention 11 returns B unchanged when either operand is a NaN, or when the strict comparison is false. In this convention all zeros compare equal, whatever their sign.
- R7: With no NaN input, ordering follows sign-magnitude value. In conventions 00, 01 and 10, -0.0 is strictly less than +0.0. Min returns A only when A is strictly less than B; max returns A only when A is strictly greater than B; otherwise both return B.
- R8: In the magnitude-first variants with no NaN input and unequal absolute values, min returns the operand with the smaller absolute value and max returns the one with the larger. Equal absolute values fall back to the same convention without the magnitude variant.
- R9: `snan_flag` is set one cycle after an accepted operation that has a signaling NaN input. It stays set until reset.
- R10: `wr_en` is high one cycle after an accepted operation, unless `inv_en` was set and a signaling NaN was present. `result` updates only on accepted operations.
- R11: After a clock edge with `rst_n` low, `result` is 0 and both `wr_en` and `snan_flag` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_a | input | 64 | Operand A, IEEE 754 double |
| op_b | input | 64 | Operand B, IEEE 754 double |
| mode | input | 4 | Min/max, magnitude and NaN-convention select |
| inv_en | input | 1 | Invalid-operation exception enable |
| result | output | 64 | Selected value, registered |
| wr_en | output | 1 | Destination write enable, registered |
| snan_flag | output | 1 | Sticky signaling-NaN invalid flag |

## Verification
The only state in the unit is the output register and the sticky flag. Any wrong decision in the classifier, the comparator or the NaN selector therefore shows up on `result` in the cycle right after the operation. A wrong quiet bit, a wrong operand or a wrong sign on a zero is visible as soon as it is made. A missed or spurious signaling-NaN detection appears one cycle later on both `wr_en` and `snan_flag`. Because the flag is sticky, a spurious set stays visible for every later cycle until reset. The stimulus sweeps every mode over ±0, ±infinity, quiet and signaling NaNs in both operand positions, equal magnitudes of opposite sign, denormals and random normals.

// File: rtl/fmm_pkg.sv
// Package fmm_pkg
// Shared mode encoding for the min/max unit: the NaN-convention enum,
// the decoded mode struct and the decode function. Assumes the mode
// field is 4 bits, with the min/max select in the most significant bit.
package fmm_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        CONV_NUM08 = 2'b00,
        CONV_MIN19 = 2'b01,
        CONV_NUM19 = 2'b10,
        CONV_CSEL  = 2'b11
    } nan_conv_e;

    typedef struct packed {
        logic      is_max;
        logic      use_mag;
        nan_conv_e conv;
    } mm_mode_t;

    // Split the raw mode bits into their three fields.
    function automatic mm_mode_t decode_mode(input logic [MODE_W-1:0] raw);
        mm_mode_t m;
        m.is_max  = raw[3];
        m.use_mag = raw[2];
        m.conv    = nan_conv_e'(raw[1:0]);
        return m;
    endfunction

endpackage

// File: rtl/fmm_classify.sv
// Module fmm_classify
// Classifies one IEEE 754 operand. It reports NaN, signaling NaN and
// zero, and it returns the absolute value and the quieted encoding.
// Assumes the layout sign | exponent (EXP_W bits) | fraction.
module fmm_classify #(
    parameter int W     = 64,
    parameter int EXP_W = 11
) (
    input  logic [W-1:0] op,
    output logic         is_nan,
    output logic         is_snan,
    output logic         is_zero,
    output logic [W-1:0] abs_val,
    output logic [W-1:0] quieted
);
    localparam int FRAC_W = W - 1 - EXP_W;
    localparam int QBIT   = FRAC_W - 1;
    localparam logic [W-1:0] INF_MAG = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    // Derive the class flags from the sign-stripped magnitude.
    always_comb begin
        abs_val = {1'b0, op[W-2:0]};
        is_nan  = abs_val > INF_MAG;
        is_snan = is_nan && !op[QBIT];
        is_zero = (abs_val == '0);
        quieted = op;
        quieted[QBIT] = 1'b1;
    end

endmodule

// File: rtl/fmm_order.sv
// Module fmm_order
// The sign-magnitude ordering core. It forms the comparison operands
// (magnitude substitution, zero folding for compare-select, and a swap
// for max) and decides whether operand A is strictly preferred.
// Assumes that neither operand is a NaN when the decision is used.
module fmm_order #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] abs_a,
    input  logic [W-1:0] abs_b,
    input  logic         zero_a,
    input  logic         zero_b,
    input  logic         is_max,
    input  logic         use_mag,
    input  logic         fold_zero,
    output logic         pick_a
);
    logic [W-1:0] cmp_l;
    logic [W-1:0] cmp_r;
    logic [W-1:0] lhs;
    logic [W-1:0] rhs;

    // Strict less-than between two sign-magnitude encodings.
    function automatic logic smag_lt(input logic [W-1:0] l, input logic [W-1:0] r);
        logic res;
        if (l[W-1] && !r[W-1])
            res = 1'b1;
        else if (!l[W-1] && r[W-1])
            res = 1'b0;
        else if (l[W-1])
            res = l[W-2:0] > r[W-2:0];
        else
            res = l[W-2:0] < r[W-2:0];
        return res;
    endfunction

    // Choose what gets compared: raw values or absolute values.
    always_comb begin
        cmp_l = a;
        cmp_r = b;
        if (use_mag && (abs_a != abs_b)) begin
            cmp_l = abs_a;
            cmp_r = abs_b;
        end
        if (fold_zero && zero_a)
            cmp_l = '0;
        if (fold_zero && zero_b)
            cmp_r = '0;
    end

    // Swap the sides for max so that a single less-than serves both.
    always_comb begin
        lhs    = is_max ? cmp_r : cmp_l;
        rhs    = is_max ? cmp_l : cmp_r;
        pick_a = smag_lt(lhs, rhs);
    end

endmodule

// File: rtl/fmm_nan_sel.sv
// Module fmm_nan_sel
// The NaN-propagation selector. When at least one operand is a NaN, it
// picks the value returned under the chosen convention. Assumes the
// classifier flags and quieted encodings come from fmm_classify.
module fmm_nan_sel
    import fmm_pkg::*;
#(
    parameter int W = 64
) (
    input  nan_conv_e    conv,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] a_q,
    input  logic [W-1:0] b_q,
    input  logic         nan_a,
    input  logic         nan_b,
    input  logic         snan_a,
    input  logic         snan_b,
    output logic [W-1:0] nan_res
);
    // Apply the priority rules of the selected convention.
    always_comb begin
        nan_res = b;
        unique case (conv)
            CONV_NUM08: begin
                if (snan_a)
                    nan_res = a_q;
                else if (snan_b)
                    nan_res = b_q;
                else if (nan_a && nan_b)
                    nan_res = a_q;
                else if (nan_a)
                    nan_res = b;
                else
                    nan_res = a;
            end
            CONV_MIN19: nan_res = nan_a ? a_q : b_q;
            CONV_NUM19: begin
                if (nan_a && nan_b)
                    nan_res = a_q;
                else if (nan_a)
                    nan_res = b;
                else
                    nan_res = a;
            end
            CONV_CSEL: nan_res = b;
            default:   nan_res = b;
        endcase
    end

endmodule

// File: rtl/fmm_unit.sv
// Module fmm_unit
// Top of the multi-mode floating-point min/max unit. It classifies both
// operands, orders them, resolves NaN inputs, and registers the result,
// the write enable and the sticky signaling-NaN flag. Latency is one
// cycle. Assumes a synchronous active-low reset.
module fmm_unit
    import fmm_pkg::*;
#(
    parameter int W     = 64,
    parameter int EXP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [MODE_W-1:0] mode,
    input  logic              inv_en,
    output logic [W-1:0]      result,
    output logic              wr_en,
    output logic              snan_flag
);
    localparam int NOPS = 2;

    mm_mode_t     md;
    logic [W-1:0] ops     [NOPS];
    logic [W-1:0] abs_v   [NOPS];
    logic [W-1:0] quiet_v [NOPS];
    logic         nan_v   [NOPS];
    logic         snan_v  [NOPS];
    logic         zero_v  [NOPS];
    logic         pick_a;
    logic         any_nan;
    logic         any_snan;
    logic [W-1:0] nan_res;
    logic [W-1:0] res_next;

    // Decode the mode and gather the operands into an array.
    always_comb begin
        md     = decode_mode(mode);
        ops[0] = op_a;
        ops[1] = op_b;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fmm_classify #(.W(W), .EXP_W(EXP_W)) u_cls (
            .op      (ops[g]),
            .is_nan  (nan_v[g]),
            .is_snan (snan_v[g]),
            .is_zero (zero_v[g]),
            .abs_val (abs_v[g]),
            .quieted (quiet_v[g])
        );
    end

    fmm_order #(.W(W)) u_order (
        .a         (op_a),
        .b         (op_b),
        .abs_a     (abs_v[0]),
        .abs_b     (abs_v[1]),
        .zero_a    (zero_v[0]),
        .zero_b    (zero_v[1]),
        .is_max    (md.is_max),
        .use_mag   (md.use_mag),
        .fold_zero (md.conv == CONV_CSEL),
        .pick_a    (pick_a)
    );

    fmm_nan_sel #(.W(W)) u_nan (
        .conv    (md.conv),
        .a       (op_a),
        .b       (op_b),
        .a_q     (quiet_v[0]),
        .b_q     (quiet_v[1]),
        .nan_a   (nan_v[0]),
        .nan_b   (nan_v[1]),
        .snan_a  (snan_v[0]),
        .snan_b  (snan_v[1]),
        .nan_res (nan_res)
    );

    // Merge the NaN path and the ordered path into the next result.
    always_comb begin
        any_nan  = nan_v[0] || nan_v[1];
        any_snan = snan_v[0] || snan_v[1];
        res_next = any_nan ? nan_res : (pick_a ? op_a : op_b);
    end

    // Output stage: result, write enable and sticky invalid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            wr_en     <= 1'b0;
            snan_flag <= 1'b0;
        end else begin
            wr_en <= in_valid && !(inv_en && any_snan);
            if (in_valid)
                result <= res_next;
            if (in_valid && any_snan)
                snan_flag <= 1'b1;
        end
    end

    AST_WE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_en && any_snan) |=> !wr_en); // R10
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && $stable(result))); // R10
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_snan) |=> snan_flag); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        snan_flag |=> snan_flag); // R9
    AST_PICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_nan) |=> (result == $past(op_a) || result == $past(op_b))); // R7
    AST_MIN19_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_nan && md.conv == CONV_MIN19)
        |=> (result[W-2 -: EXP_W] == {EXP_W{1'b1}} && result[W-EXP_W-2])); // R4
    AST_CSEL_NAN_B: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_nan && md.conv == CONV_CSEL) |=> (result == $past(op_b))); // R6
    AST_MAG_SMALLER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_nan && md.use_mag && !md.is_max && abs_v[0] < abs_v[1])
        |=> (result == $past(op_a))); // R8

endmodule

// File: tb/sim_fmm_unit.sv
`timescale 1ns/1ps
module sim_fmm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  mode = '0;
    logic        inv_en = 1'b0;
    logic [63:0] result;
    logic        wr_en;
    logic        snan_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    logic [63:0] exp_res = '0;
    logic        exp_we = 1'b0;
    logic        exp_flag = 1'b0;
    string       exp_tag = "R11";
    bit          in_rst = 1'b1;

    fmm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .inv_en(inv_en), .result(result), .wr_en(wr_en),
        .snan_flag(snan_flag)
    );

    always #2 clk = ~clk;

    function automatic bit isnan(input logic [63:0] x);
        return (x & 64'h7FFF_FFFF_FFFF_FFFF) > 64'h7FF0_0000_0000_0000;
    endfunction
    function automatic bit issnan(input logic [63:0] x);
        return isnan(x) && !x[51];
    endfunction
    function automatic logic [63:0] qz(input logic [63:0] x);
        return x | (64'h1 << 51);
    endfunction

    // Behavioural reference for the selected value.
    function automatic logic [63:0] ref_val(input logic [63:0] a, input logic [63:0] b,
                                            input logic [3:0] m);
        bit na = isnan(a), nb = isnan(b);
        bit mx = m[3], mg = m[2];
        logic [63:0] ma = {1'b0, a[62:0]};
        logic [63:0] mb = {1'b0, b[62:0]};
        real ra = $bitstoreal(a), rb = $bitstoreal(b);
        if (na || nb) begin
            case (m[1:0])
                2'b00: begin
                    if (issnan(a)) return qz(a);
                    if (issnan(b)) return qz(b);
                    if (na && nb) return qz(a);
                    return na ? b : a;
                end
                2'b01: return na ? qz(a) : qz(b);
                2'b10: begin
                    if (na && nb) return qz(a);
                    return na ? b : a;
                end
                default: return b;
            endcase
        end
        if (mg && ma != mb) begin
            if (mx) return ($bitstoreal(ma) > $bitstoreal(mb)) ? a : b;
            return ($bitstoreal(ma) < $bitstoreal(mb)) ? a : b;
        end
        if (m[1:0] != 2'b11 && ma == 0 && mb == 0 && a[63] != b[63]) begin
            if (mx) return a[63] ? b : a;
            return a[63] ? a : b;
        end
        if (mx) return (ra > rb) ? a : b;
        return (ra < rb) ? a : b;
    endfunction

    function automatic string ref_tag(input logic [63:0] a, input logic [63:0] b,
                                      input logic [3:0] m);
        if (isnan(a) || isnan(b)) begin
            case (m[1:0])
                2'b00: return "R3";
                2'b01: return "R4";
                2'b10: return "R5";
                default: return "R6";
            endcase
        end
        if (m[2] && a[62:0] != b[62:0]) return "R8";
        if (m[1:0] == 2'b11) return "R6";
        return "R7";
    endfunction

    // Reference model: advance the expected outputs on each clock.
    always @(posedge clk) begin
        cyc++;
        chk_on = 1'b1;
        if (!rst_n) begin
            exp_res = '0; exp_we = 1'b0; exp_flag = 1'b0; in_rst = 1'b1;
        end else begin
            in_rst = 1'b0;
            exp_we = in_valid && !(inv_en && (issnan(op_a) || issnan(op_b)));
            if (in_valid) begin
                exp_res = ref_val(op_a, op_b, mode);
                exp_tag = ref_tag(op_a, op_b, mode);
                if (issnan(op_a) || issnan(op_b)) exp_flag = 1'b1;
            end
        end
    end

    // Compare the outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks++;
            if (result !== exp_res) begin
                errors++;
                $display("FAIL %s result=%h expected=%h mode=%h", in_rst ? "R11" : exp_tag,
                         result, exp_res, mode);
            end
            checks++;
            if (wr_en !== exp_we) begin
                errors++;
                $display("FAIL %s wr_en=%b expected=%b", in_rst ? "R11" : "R10", wr_en, exp_we);
            end
            checks++;
            if (snan_flag !== exp_flag) begin
                errors++;
                $display("FAIL %s snan_flag=%b expected=%b", in_rst ? "R11" : "R9",
                         snan_flag, exp_flag);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input bit v, input logic [63:0] a, input logic [63:0] b,
                         input logic [3:0] m, input bit ie);
        @(negedge clk);
        in_valid = v; op_a = a; op_b = b; mode = m; inv_en = ie;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [63:0] rnd_fp();
        logic [63:0] x;
        x = {$urandom, $urandom};
        case ($urandom_range(0, 3))
            0: x[62:52] = 11'd0;
            1: x[62:52] = 11'($urandom_range(1000, 1050));
            default: if (x[62:52] == 11'h7FF) x[62:52] = 11'h7FE;
        endcase
        return x;
    endfunction

    logic [63:0] sv_tab [14];

    initial begin
        sv_tab[0]  = 64'h0000_0000_0000_0000; // +0
        sv_tab[1]  = 64'h8000_0000_0000_0000; // -0
        sv_tab[2]  = 64'h7FF0_0000_0000_0000; // +inf
        sv_tab[3]  = 64'hFFF0_0000_0000_0000; // -inf
        sv_tab[4]  = 64'h7FF8_0000_0000_0001; // quiet NaN
        sv_tab[5]  = 64'hFFF8_0000_0000_0000; // negative quiet NaN
        sv_tab[6]  = 64'h7FF0_0000_0000_0001; // R2: signaling NaN, bit 51 clear
        sv_tab[7]  = 64'hFFF4_0000_0000_0000; // R2: negative signaling NaN
        sv_tab[8]  = 64'h3FF0_0000_0000_0000; // 1.0
        sv_tab[9]  = 64'hBFF0_0000_0000_0000; // -1.0
        sv_tab[10] = 64'h4000_0000_0000_0000; // 2.0
        sv_tab[11] = 64'h0000_0000_0000_0003; // denormal
        sv_tab[12] = 64'h8000_0000_0000_0005; // negative denormal
        sv_tab[13] = 64'hC000_0000_0000_0000; // -2.0

        // R11: reset state is sampled while rst_n is held low.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: the same pair under min and under max must differ.
        drive(1'b1, sv_tab[8], sv_tab[10], 4'b0000, 1'b0);
        drive(1'b1, sv_tab[8], sv_tab[10], 4'b1000, 1'b0);
        // R7: -0 against +0 in both positions.
        drive(1'b1, sv_tab[0], sv_tab[1], 4'b0001, 1'b0);
        drive(1'b1, sv_tab[1], sv_tab[0], 4'b1010, 1'b0);
        // R6: zeros compare equal under compare-select, B returned.
        drive(1'b1, sv_tab[1], sv_tab[0], 4'b0011, 1'b0);
        // R8: equal magnitudes, opposite signs, fall back.
        drive(1'b1, sv_tab[9], sv_tab[8], 4'b0100, 1'b0);
        drive(1'b1, sv_tab[13], sv_tab[8], 4'b1100, 1'b0);
        // R10: idle cycle, no write and result held.
        drive(1'b0, sv_tab[6], sv_tab[6], 4'b0000, 1'b1);

        // Sweep every mode over every special pair (R3, R4, R5, R6, R10).
        for (int m = 0; m < 16; m++)
            for (int i = 0; i < 14; i++)
                for (int j = 0; j < 14; j++)
                    drive(1'b1, sv_tab[i], sv_tab[j], 4'(m), 1'((i + j + m) & 1));

        // R9: the flag clears only through reset.
        drive(1'b0, '0, '0, 4'b0000, 1'b0);
        do_reset();
        drive(1'b1, sv_tab[8], sv_tab[9], 4'b0000, 1'b0);
        drive(1'b1, sv_tab[7], sv_tab[8], 4'b0010, 1'b1);

        // Random normals and denormals with equal-magnitude pairs mixed in.
        for (int k = 0; k < 6000; k++) begin
            logic [63:0] a = rnd_fp();
            logic [63:0] b = ($urandom_range(0, 5) == 0) ? (a ^ 64'h8000_0000_0000_0000) : rnd_fp();
            if ($urandom_range(0, 15) == 0) b = sv_tab[$urandom_range(0, 13)];
            drive($urandom_range(0, 7) != 0, a, b, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
        end

        drive(1'b0, '0, '0, 4'b0000, 1'b0);
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule